// File: doc/BRIEF.md
# Dual Limit Watchdog Comparator

This block sits beside a data-acquisition sequencer. When an instruction runs in limit-compare mode, it checks one converted signed sample against two thresholds, one after the other. Each threshold has its own sign and its own direction flag. The flag decides whether the threshold trips when the sample is above it or when the sample is below it. A trip on either threshold gives a one-cycle interrupt pulse on that threshold's own output. The block raises a done strobe once the second comparison has been made, so the sequencer can move on.

When the instruction does not ask for limit comparison, the block gives back only a done strobe and the sequencer treats the cycle as a normal conversion. When external synchronisation is enabled, each of the two comparisons waits for its own rising edge on the sync input. The sample, both limit fields, the resolution flag and the sync flag are captured when the block is started. Later changes on those inputs do not affect the run in progress.

The control is one finite-state machine with these states:
- **IDLE**: waiting for a start.
- **ARM1**: waiting for a sync edge before the first comparison.
- **CMP1**: the first comparison is presented.
- **ARM2**: waiting for a sync edge before the second comparison.
- **CMP2**: the second comparison is presented and done is raised.
- **CONV**: the done strobe for a run with compare mode off.

The transitions are:
- IDLE→CONV on a start with compare mode clear.
- IDLE→ARM1 on a start with compare mode and sync both set.
- IDLE→CMP1 on a start with compare mode set and sync clear.
- ARM1→CMP1 on a sync rising edge.
- CMP1→ARM2 when the captured sync flag is set.
- CMP1→CMP2 when the captured sync flag is clear.
- ARM2→CMP2 on a sync rising edge.
- CMP2→IDLE and CONV→IDLE unconditionally.

Top module: `wdc_dual_limit`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, irq1_o, irq2_o and done_o are all low.
- R2: Each limit field is 10 bits. Bits 7:0 are the magnitude, bit 8 is the sign and bit 9 is the direction. The threshold value is the 9-bit two's-complement number {bit 8, bits 7:0}, so for example 0x1F0 means -16.
- R3: With direction 1, a limit trips when the signed sample is strictly greater than the threshold. With direction 0, it trips when the sample is strictly less than the threshold. A sample equal to the threshold never trips.
- R4: With coarse_i = 1 (8-bit plus sign), the threshold is the field value itself. With coarse_i = 0 (12-bit plus sign), the threshold is the field value multiplied by 16.
- R5: With compare mode set and sync clear, a start sampled at clock edge k makes irq1_o reflect the limit-1 result for exactly the one cycle after edge k. Then irq2_o reflects the limit-2 result and done_o is high for exactly the one cycle after edge k+1.
- R6: done_o is a one-cycle pulse, and irq2_o is only ever high together with done_o. irq1_o is never high in the same cycle as irq2_o or done_o.
- R7: With sync set, the first comparison waits for a rising edge of sync_i. An edge sampled at edge m shows the limit-1 result in the cycle after m. The second comparison then needs a new rising edge, and holding sync_i high does not advance it.
- R8: A start with compare mode clear raises done_o for the single cycle after the start edge, with both interrupt outputs low.
- R9: Once a run has started, a further start and changes to the sample, limit fields, mode, resolution and sync-enable inputs do not affect the run. The results reflect the values captured at the start, and no second run follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run, taken only when idle |
| cmp_mode_i | input | 1 | 1 = limit-compare run, 0 = plain conversion |
| coarse_i | input | 1 | 1 = 8-bit plus sign scale, 0 = 12-bit plus sign scale |
| sync_en_i | input | 1 | 1 = each comparison waits for a sync rising edge |
| sync_i | input | 1 | External sync line |
| sample_i | input | SAMPLE_W (13) | Converted signed sample, two's complement |
| lim1_i | input | MAG_W+2 (10) | Limit-1 field: direction, sign, magnitude |
| lim2_i | input | MAG_W+2 (10) | Limit-2 field: direction, sign, magnitude |
| irq1_o | output | 1 | Limit-1 trip pulse |
| irq2_o | output | 1 | Limit-2 trip pulse |
| done_o | output | 1 | Run-complete strobe |

## Verification
The bench places samples exactly on the threshold and one count either side of it, at both scales and with negative thresholds. A comparison that is not strict, a missing sign extension or a missing ×16 shift would then raise or drop an interrupt where it should not. In sync mode, sync_i is held high across the gap between the two comparisons. A design that compares the sync level instead of detecting its edge would finish early. Mid-run starts and input changes are applied while the block waits for a sync edge. A design that does not capture its inputs at the start would report results from the new values or start a second run.

// File: rtl/wdc_pkg.sv
package wdc_pkg;

    localparam int NUM_LIMITS = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM1,
        ST_CMP1,
        ST_ARM2,
        ST_CMP2,
        ST_CONV
    } wdc_state_e;

endpackage

// File: rtl/wdc_limit_decode.sv
// Turns a limit field into a signed threshold at the sample's scale.
module wdc_limit_decode #(
    parameter int MAG_W      = 8,
    parameter int SAMPLE_W   = 13,
    parameter int FINE_SHIFT = 4
) (
    input  logic [MAG_W+1:0]    lim_i,
    input  logic                coarse_i,
    output logic [SAMPLE_W-1:0] thr_o,
    output logic                dir_gt_o
);
    localparam int VAL_W = MAG_W + 1;
    localparam int EXT_W = SAMPLE_W - VAL_W;

    logic [VAL_W-1:0]    val;
    logic [SAMPLE_W-1:0] ext;

    always_comb begin
        val      = lim_i[VAL_W-1:0];
        ext      = {{EXT_W{val[VAL_W-1]}}, val};
        thr_o    = coarse_i ? ext : (ext << FINE_SHIFT);
        dir_gt_o = lim_i[MAG_W+1];
    end
endmodule

// File: rtl/wdc_limit_cmp.sv
// Strict signed comparison in the selected direction.
module wdc_limit_cmp #(
    parameter int SAMPLE_W = 13
) (
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic [SAMPLE_W-1:0] thr_i,
    input  logic                dir_gt_i,
    output logic                hit_o
);
    always_comb begin
        if (dir_gt_i) hit_o = $signed(sample_i) > $signed(thr_i);
        else          hit_o = $signed(sample_i) < $signed(thr_i);
    end
endmodule

// File: rtl/wdc_sync_edge.sv
// Rising-edge detector on the external sync line.
module wdc_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_i,
    output logic rise_o
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_i;
    end

    assign rise_o = sync_i & ~prev_q;
endmodule

// File: rtl/wdc_dual_limit.sv
module wdc_dual_limit
    import wdc_pkg::*;
#(
    parameter int SAMPLE_W   = 13,
    parameter int MAG_W      = 8,
    parameter int FINE_SHIFT = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                cmp_mode_i,
    input  logic                coarse_i,
    input  logic                sync_en_i,
    input  logic                sync_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic [MAG_W+1:0]    lim1_i,
    input  logic [MAG_W+1:0]    lim2_i,
    output logic                irq1_o,
    output logic                irq2_o,
    output logic                done_o
);
    localparam int LIM_W = MAG_W + 2;

    wdc_state_e state_q, state_d;

    logic [SAMPLE_W-1:0]                  sample_q;
    logic [NUM_LIMITS-1:0][LIM_W-1:0]     lim_q;
    logic                                 coarse_q;
    logic                                 sync_q;
    logic [NUM_LIMITS-1:0][SAMPLE_W-1:0]  thr;
    logic [NUM_LIMITS-1:0]                dir_gt;
    logic [NUM_LIMITS-1:0]                hit;
    logic                                 sync_rise;
    logic                                 busy;
    logic                                 accept;

    assign accept = (state_q == ST_IDLE) && start_i;

    // Capture of run parameters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sample_q <= '0;
            lim_q    <= '0;
            coarse_q <= 1'b0;
            sync_q   <= 1'b0;
        end else if (accept) begin
            sample_q <= sample_i;
            lim_q    <= {lim2_i, lim1_i};
            coarse_q <= coarse_i;
            sync_q   <= sync_en_i;
        end
    end

    wdc_sync_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (sync_i),
        .rise_o (sync_rise)
    );

    for (genvar g = 0; g < NUM_LIMITS; g++) begin : g_lim
        wdc_limit_decode #(
            .MAG_W      (MAG_W),
            .SAMPLE_W   (SAMPLE_W),
            .FINE_SHIFT (FINE_SHIFT)
        ) u_dec (
            .lim_i    (lim_q[g]),
            .coarse_i (coarse_q),
            .thr_o    (thr[g]),
            .dir_gt_o (dir_gt[g])
        );

        wdc_limit_cmp #(
            .SAMPLE_W (SAMPLE_W)
        ) u_cmp (
            .sample_i (sample_q),
            .thr_i    (thr[g]),
            .dir_gt_i (dir_gt[g]),
            .hit_o    (hit[g])
        );
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (!cmp_mode_i)    state_d = ST_CONV;
                    else if (sync_en_i) state_d = ST_ARM1;
                    else                state_d = ST_CMP1;
                end
            end
            ST_ARM1: if (sync_rise) state_d = ST_CMP1;
            ST_CMP1: state_d = sync_q ? ST_ARM2 : ST_CMP2;
            ST_ARM2: if (sync_rise) state_d = ST_CMP2;
            ST_CMP2: state_d = ST_IDLE;
            ST_CONV: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        irq1_o = 1'b0;
        irq2_o = 1'b0;
        done_o = 1'b0;
        busy   = 1'b1;
        unique case (state_q)
            ST_IDLE: busy = 1'b0;
            ST_CMP1: irq1_o = hit[0];
            ST_CMP2: begin
                irq2_o = hit[1];
                done_o = 1'b1;
            end
            ST_CONV: done_o = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/wdc_dual_limit_chk.sv
module wdc_dual_limit_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic cmp_mode_i,
    input logic sync_en_i,
    input logic busy,
    input logic irq1_o,
    input logic irq2_o,
    input logic done_o
);
    p_irq1_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq1_o |=> !irq1_o);

    p_direct_seq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy && cmp_mode_i && !sync_en_i) |=> !done_o ##1 done_o);

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_irq1_alone_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq1_o |-> (!irq2_o && !done_o));

    p_irq2_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq2_o |-> done_o);

    p_plain_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy && !cmp_mode_i) |=> (done_o && !irq1_o && !irq2_o));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!irq1_o && !irq2_o && !done_o));
endmodule

bind wdc_dual_limit wdc_dual_limit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .cmp_mode_i (cmp_mode_i),
    .sync_en_i  (sync_en_i),
    .busy       (busy),
    .irq1_o     (irq1_o),
    .irq2_o     (irq2_o),
    .done_o     (done_o)
);

// File: tb/test_wdc_dual_limit.sv
module test_wdc_dual_limit;
    localparam int SW = 13;
    localparam int LW = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, cmp_mode = 1'b0, coarse = 1'b0, sync_en = 1'b0, sync_in = 1'b0;
    logic [SW-1:0] sample = '0;
    logic [LW-1:0] lim1 = '0, lim2 = '0;
    logic irq1, irq2, done;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    wdc_dual_limit i_wdc_dual_limit (
        .clk(clk), .rst_n(rst_n), .start_i(start), .cmp_mode_i(cmp_mode),
        .coarse_i(coarse), .sync_en_i(sync_en), .sync_i(sync_in),
        .sample_i(sample), .lim1_i(lim1), .lim2_i(lim2),
        .irq1_o(irq1), .irq2_o(irq2), .done_o(done)
    );

    function automatic logic [LW-1:0] fld(input bit gt, input int val);
        logic [8:0] v;
        v = 9'(val);
        return {gt, v};
    endfunction

    task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {irq1,irq2,done} actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic launch(input int smp, input logic [LW-1:0] l1, input logic [LW-1:0] l2,
                          input bit crs, input bit mode, input bit sen);
        @(negedge clk);
        sample = SW'(smp); lim1 = l1; lim2 = l2;
        coarse = crs; cmp_mode = mode; sync_en = sen; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Direct run: check both comparison cycles and the return to idle.
    task automatic t_direct(input string tag, input int smp, input logic [LW-1:0] l1,
                            input logic [LW-1:0] l2, input bit crs, input bit e1, input bit e2);
        launch(smp, l1, l2, crs, 1'b1, 1'b0);
        chk({tag, " R5 first cycle"}, {irq1, irq2, done}, {e1, 1'b0, 1'b0});
        @(negedge clk);
        chk({tag, " R5 second cycle"}, {irq1, irq2, done}, {1'b0, e2, 1'b1});
        @(negedge clk);
        chk({tag, " R6 done single"}, {irq1, irq2, done}, 3'b000);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 in reset", {irq1, irq2, done}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {irq1, irq2, done}, 3'b000);
    endtask

    task automatic t_plain;
        launch(100, fld(1, 0), fld(0, 200), 1'b1, 1'b0, 1'b0);
        chk("R8 done without irq", {irq1, irq2, done}, 3'b001);
        @(negedge clk);
        chk("R8 single cycle", {irq1, irq2, done}, 3'b000);
    endtask

    task automatic t_sync;
        launch(50, fld(1, 10), fld(1, 20), 1'b1, 1'b1, 1'b1);
        chk("R7 waits edge 1", {irq1, irq2, done}, 3'b000);
        @(negedge clk);
        chk("R7 still waiting", {irq1, irq2, done}, 3'b000);
        sync_in = 1'b1;
        @(negedge clk);
        chk("R7 first compare", {irq1, irq2, done}, 3'b100);
        @(negedge clk);
        chk("R7 level held 1", {irq1, irq2, done}, 3'b000);
        @(negedge clk);
        chk("R7 level held 2", {irq1, irq2, done}, 3'b000);
        sync_in = 1'b0;
        @(negedge clk);
        chk("R7 line low", {irq1, irq2, done}, 3'b000);
        sync_in = 1'b1;
        @(negedge clk);
        chk("R7 second compare", {irq1, irq2, done}, 3'b011);
        sync_in = 1'b0;
        @(negedge clk);
        chk("R7 back idle", {irq1, irq2, done}, 3'b000);
    endtask

    task automatic t_busy;
        launch(100, fld(1, 50), fld(0, 50), 1'b1, 1'b1, 1'b1);
        sample = '0; lim1 = fld(1, 200); lim2 = fld(0, 200);
        coarse = 1'b0; cmp_mode = 1'b0; sync_en = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R9 restart ignored", {irq1, irq2, done}, 3'b000);
        sync_in = 1'b1;
        @(negedge clk);
        chk("R9 captured limit 1", {irq1, irq2, done}, 3'b100);
        sync_in = 1'b0;
        @(negedge clk);
        sync_in = 1'b1;
        @(negedge clk);
        chk("R9 captured limit 2", {irq1, irq2, done}, 3'b001);
        sync_in = 1'b0;
        @(negedge clk);
        chk("R9 no second run a", {irq1, irq2, done}, 3'b000);
        @(negedge clk);
        chk("R9 no second run b", {irq1, irq2, done}, 3'b000);
    endtask

    initial begin
        t_reset();
        // R3: above/below at 8-bit scale
        t_direct("R3 above", 17, fld(1, 16), fld(0, 16), 1'b1, 1'b1, 1'b0);
        t_direct("R3 below", 15, fld(1, 16), fld(0, 16), 1'b1, 1'b0, 1'b1);
        t_direct("R3 equal", 16, fld(1, 16), fld(0, 16), 1'b1, 1'b0, 1'b0);
        // R2: negative threshold -16 (field 0x1F0)
        t_direct("R2 negative", -17, fld(0, -16), fld(1, -16), 1'b1, 1'b1, 1'b0);
        t_direct("R2 neg equal", -16, fld(0, -16), fld(1, -16), 1'b1, 1'b0, 1'b0);
        // R4: 12-bit scale, threshold x16
        t_direct("R4 fine", 257, fld(1, 16), fld(1, 17), 1'b0, 1'b1, 1'b0);
        t_direct("R4 fine equal", 256, fld(1, 16), fld(0, 16), 1'b0, 1'b0, 1'b0);
        t_direct("R4 fine neg", -2049, fld(0, -128), fld(1, -128), 1'b0, 1'b1, 1'b0);
        t_direct("R4 coarse same field", 17, fld(1, 16), fld(0, 17), 1'b1, 1'b1, 1'b0);
        t_plain();
        t_sync();
        t_busy();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule